// File: doc/BRIEF.md
# Prescaled Wide-Range Phase Detector

This block measures the phase offset between a recovered line clock and a local oscillator clock when the two can drift apart by many unit intervals (UI). A plain two-flop phase-frequency detector is linear over only one input period. Here each input is first divided by sixteen, so the same detector covers about sixteen input periods before it slips. The intended input is a 2 Mbit/s line clock that has already been recovered upstream.

Both inputs are asynchronous to a fast system clock. Each one passes through a synchroniser and a rising-edge detector. Each edge stream drives its own wrapping counter, and a counter wrap is the event the detector compares. The detector drives UP and DOWN flags. A signed accumulator turns the time between the two events into an error measured in system clocks, and presents that error once per comparison. A loop filter and oscillator sit outside the block. The block never changes either clock.

Top module: `wide_phase_det`

## Requirements
- R1: Each input is synchronised in two stages and a rising edge is recognised exactly once. When that edge completes a divided period, the matching flag is high in the third system-clock cycle after the cycle in which the pin first reads 1.
- R2: Reset loads each counter from its preset input. An event occurs on the edge that steps the counter from 15 to 0, so the first event arrives on edge number 16 − preset.
- R3: A reference event sets `up` and an oscillator event sets `dn`. Each flag stays set until both flags are set.
- R4: When `up` and `dn` are both set, both clear on the next clock, so the overlap lasts exactly one cycle.
- R5: The accumulator adds +1 in each cycle with only `up` set and −1 in each cycle with only `dn` set. In the cycle after the overlap it presents that total on `err_count` with a one-cycle `err_valid` pulse, and it restarts from 0. A positive value means the reference leads.
- R6: The accumulated error saturates at +(2^(ERR_W−1)−1) and at −(2^(ERR_W−1)−1) instead of wrapping.
- R7: Further events on the side whose flag is already set have no effect. The flag stays set, the other flag stays clear, and no error is presented.
- R8: While `rst` is high and after it, before any event, `up`, `dn`, `err_valid` and `err_count` are 0.
- R9: With equal input rates and equal presets, a lag of up to 15 input periods is reported without slip as the lag in system clocks, with the sign giving which input leads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than both inputs |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Recovered line clock, asynchronous |
| osc_in | input | 1 | Local oscillator clock, asynchronous |
| ref_preset | input | DIV_W | Start value loaded into the reference counter at reset |
| osc_preset | input | DIV_W | Start value loaded into the oscillator counter at reset |
| up | output | 1 | Reference event seen and not yet matched |
| dn | output | 1 | Oscillator event seen and not yet matched |
| err_valid | output | 1 | One-cycle strobe marking a new error value |
| err_count | output | ERR_W | Signed phase error in system clocks, held between strobes |

## Verification
The assertions check on every cycle that each edge pulse lasts one cycle, that an event leaves its counter at zero, that a set flag holds while it waits for its partner, that the overlap ends after one cycle, that every overlap is followed by an error strobe, and that the accumulator never reaches the negative extreme. The actual error values, the effect of the presets, the latency from pin to flag, and the behaviour across the full sixteen-period range and under saturation can only be shown by the bench's scenarios, which drive square waves with known offsets.

// File: rtl/wpd_pkg.sv
`timescale 1ns/1ps
package wpd_pkg;
    typedef enum logic [0:0] {
        CH_REF = 1'b0,
        CH_OSC = 1'b1
    } wpd_chan_e;

    localparam int NUM_CH = 2;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_state_t;
endpackage

// File: rtl/wpd_edge_sync.sv
`timescale 1ns/1ps
module wpd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
        st_d.prev  = st_q.chain[STAGES-1];
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/wpd_wrap_div.sv
`timescale 1ns/1ps
module wpd_wrap_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] preset,
    input  logic             rise_i,
    output logic             ev_o
);
    localparam logic [DIV_W-1:0] TOP  = {DIV_W{1'b1}};
    localparam logic [DIV_W-1:0] STEP = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (rise_i) begin
            cnt_d = cnt_q + STEP;
        end
        if (rst) begin
            cnt_d = preset;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign ev_o = rise_i && (cnt_q == TOP);

    assert_event_wraps_R2: assert property (@(posedge clk) disable iff (rst)
        ev_o |=> (cnt_q == '0));
endmodule

// File: rtl/wpd_pfd_core.sv
`timescale 1ns/1ps
module wpd_pfd_core
    import wpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_ref_i,
    input  logic ev_osc_i,
    output logic up_o,
    output logic dn_o
);
    pfd_state_t st_d, st_q;
    logic       both;

    always_comb begin
        both = st_q.up & st_q.dn;
        st_d = st_q;
        if (both) begin
            st_d.up = ev_ref_i;
            st_d.dn = ev_osc_i;
        end else begin
            st_d.up = st_q.up | ev_ref_i;
            st_d.dn = st_q.dn | ev_osc_i;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign up_o = st_q.up;
    assign dn_o = st_q.dn;

    assert_up_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (up_o && !dn_o) |=> up_o);
    assert_dn_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (dn_o && !up_o) |=> dn_o);
    assert_one_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        (up_o && dn_o && !ev_ref_i && !ev_osc_i) |=> (!up_o && !dn_o));
endmodule

// File: rtl/wpd_err_acc.sv
`timescale 1ns/1ps
module wpd_err_acc #(
    parameter int ERR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up_i,
    input  logic                    dn_i,
    output logic                    valid_o,
    output logic signed [ERR_W-1:0] err_o
);
    localparam logic signed [ERR_W-1:0] CEIL  = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] FLOOR = -CEIL;
    localparam logic signed [ERR_W-1:0] ONE   = {{(ERR_W-1){1'b0}}, 1'b1};
    localparam logic signed [ERR_W-1:0] BEYOND = {1'b1, {(ERR_W-1){1'b0}}};

    typedef struct packed {
        logic [ERR_W-1:0] acc;
        logic [ERR_W-1:0] held;
        logic             strobe;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (up_i && dn_i) begin
            st_d.held   = st_q.acc;
            st_d.strobe = 1'b1;
            st_d.acc    = '0;
        end else if (up_i) begin
            if ($signed(st_q.acc) != CEIL) begin
                st_d.acc = st_q.acc + ONE;
            end
        end else if (dn_i) begin
            if ($signed(st_q.acc) != FLOOR) begin
                st_d.acc = st_q.acc - ONE;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign valid_o = st_q.strobe;
    assign err_o   = $signed(st_q.held);

    assert_strobe_after_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        (up_i && dn_i) |=> valid_o);
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        $signed(st_q.acc) != BEYOND);
endmodule

// File: rtl/wide_phase_det.sv
`timescale 1ns/1ps
module wide_phase_det
    import wpd_pkg::*;
#(
    parameter int DIV_W       = 4,
    parameter int ERR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_in,
    input  logic                    osc_in,
    input  logic [DIV_W-1:0]        ref_preset,
    input  logic [DIV_W-1:0]        osc_preset,
    output logic                    up,
    output logic                    dn,
    output logic                    err_valid,
    output logic signed [ERR_W-1:0] err_count
);
    logic             pin  [NUM_CH];
    logic [DIV_W-1:0] pre  [NUM_CH];
    logic             rise [NUM_CH];
    logic             ev   [NUM_CH];

    assign pin[CH_REF] = ref_in;
    assign pin[CH_OSC] = osc_in;
    assign pre[CH_REF] = ref_preset;
    assign pre[CH_OSC] = osc_preset;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        wpd_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk    (clk),
            .rst    (rst),
            .din    (pin[ch]),
            .rise_o (rise[ch])
        );
        wpd_wrap_div #(.DIV_W(DIV_W)) div_i (
            .clk    (clk),
            .rst    (rst),
            .preset (pre[ch]),
            .rise_i (rise[ch]),
            .ev_o   (ev[ch])
        );
    end

    wpd_pfd_core pfd_i (
        .clk      (clk),
        .rst      (rst),
        .ev_ref_i (ev[CH_REF]),
        .ev_osc_i (ev[CH_OSC]),
        .up_o     (up),
        .dn_o     (dn)
    );

    wpd_err_acc #(.ERR_W(ERR_W)) acc_i (
        .clk     (clk),
        .rst     (rst),
        .up_i    (up),
        .dn_i    (dn),
        .valid_o (err_valid),
        .err_o   (err_count)
    );

    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |=> (!up && !dn && !err_valid && err_count == '0));
endmodule

// File: tb/wide_phase_det_tb.sv
`timescale 1ns/1ps
module wide_phase_det_tb_top;
    localparam int DIV_W = 4;
    localparam int ERR_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic osc_in = 1'b0;
    logic [DIV_W-1:0] ref_preset = '0;
    logic [DIV_W-1:0] osc_preset = '0;
    logic up, dn, err_valid;
    logic signed [ERR_W-1:0] err_count;

    int n_checks = 0;
    int n_err = 0;

    // monitor-owned counters
    int n_valid = 0;
    int n_bad = 0;
    int exp_err = 0;
    int long_both = 0;
    int n_both = 0;
    logic prev_both = 1'b0;

    always #2.5 clk = ~clk;

    wide_phase_det #(.DIV_W(DIV_W), .ERR_W(ERR_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .osc_in(osc_in),
        .ref_preset(ref_preset), .osc_preset(osc_preset),
        .up(up), .dn(dn), .err_valid(err_valid), .err_count(err_count)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (err_valid) begin
                n_valid = n_valid + 1;
                if (int'(err_count) != exp_err) n_bad = n_bad + 1;
            end
            if (up && dn) begin
                n_both = n_both + 1;
                if (prev_both) long_both = long_both + 1;
            end
        end
        prev_both = up && dn;
    end

    task automatic chk(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_reset(input int rp, input int op);
        @(negedge clk);
        rst = 1'b1;
        ref_in = 1'b0;
        osc_in = 1'b0;
        ref_preset = DIV_W'(rp);
        osc_preset = DIV_W'(op);
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    // square waves with half period h; first rising edge at cycle rd / od
    task automatic drive(input int n, input int h, input int rd, input int od,
                         input bit ren, input bit oen);
        for (int t = 0; t < n; t++) begin
            ref_in = ren && (t >= rd) && (((t - rd) % (2*h)) < h);
            osc_in = oen && (t >= od) && (((t - od) % (2*h)) < h);
            @(negedge clk);
        end
        ref_in = 1'b0;
        osc_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 up in reset", int'(up), 0);
        chk("R8 dn in reset", int'(dn), 0);
        chk("R8 err_valid in reset", int'(err_valid), 0);
        chk("R8 err_count in reset", int'(err_count), 0);
        do_reset(0, 0);
        repeat (3) @(negedge clk);
        chk("R8 up after reset", int'(up), 0);
        chk("R8 err_count after reset", int'(err_count), 0);
    endtask

    task automatic test_latency();
        do_reset(15, 15);
        ref_in = 1'b1;                 // pin reads 1 from edge E0
        @(negedge clk);
        chk("R1 up after E0", int'(up), 0);
        @(negedge clk);
        chk("R1 up after E1", int'(up), 0);
        @(negedge clk);
        chk("R1 up after E2", int'(up), 1);
        chk("R3 dn stays clear", int'(dn), 0);
        osc_in = 1'b1;                 // dn expected after E5
        @(negedge clk);
        @(negedge clk);
        chk("R3 up held", int'(up), 1);
        @(negedge clk);
        chk("R4 overlap up", int'(up), 1);
        chk("R4 overlap dn", int'(dn), 1);
        @(negedge clk);
        chk("R4 up cleared", int'(up), 0);
        chk("R4 dn cleared", int'(dn), 0);
        chk("R5 strobe", int'(err_valid), 1);
        chk("R5 error three cycles", int'(err_count), 3);
        @(negedge clk);
        chk("R5 strobe one cycle", int'(err_valid), 0);
        chk("R5 error held", int'(err_count), 3);
        ref_in = 1'b0;
        osc_in = 1'b0;
    endtask

    task automatic test_offset(input string req, input int rp, input int op,
                               input int rd, input int od, input int expv);
        int v0, b0;
        do_reset(rp, op);
        exp_err = expv;
        v0 = n_valid;
        b0 = n_bad;
        drive(300, 2, rd, od, 1'b1, 1'b1);
        chk({req, " strobes seen"}, int'((n_valid - v0) >= 3), 1);
        chk({req, " error values"}, n_bad - b0, 0);
        chk({req, " last error"}, int'(err_count), expv);
    endtask

    task automatic test_saturate(input bit ref_first);
        int v0, b0;
        do_reset(0, 0);
        v0 = n_valid;
        drive(200, 2, 0, 0, ref_first, !ref_first);
        // three events on one side: flag stays, nothing presented
        chk("R7 leading flag held", int'(ref_first ? up : dn), 1);
        chk("R7 other flag clear", int'(ref_first ? dn : up), 0);
        chk("R7 no strobe", n_valid - v0, 0);
        exp_err = ref_first ? 127 : -127;
        b0 = n_bad;
        drive(70, 2, 0, 0, !ref_first, ref_first);
        chk("R6 one strobe", n_valid - v0, 1);
        chk("R6 saturated value", int'(err_count), exp_err);
        chk("R6 value mismatches", n_bad - b0, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        test_reset();
        test_latency();
        test_offset("R9 osc lags 5 UI", 0, 0, 0, 20, 20);
        test_offset("R9 ref lags 9 UI", 0, 0, 36, 0, -36);
        test_offset("R9 lag 15 UI", 0, 0, 0, 60, 60);
        test_offset("R2 ref preset 8", 8, 0, 0, 0, 32);
        test_offset("R2 osc preset 3", 0, 3, 0, 0, -12);
        test_saturate(1'b1);
        test_saturate(1'b0);
        chk("R4 overlaps seen", int'(n_both > 0), 1);
        chk("R4 overlap longer than one cycle", long_both, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule